// File: doc/BRIEF.md
# Self-Timed Programming Sequencer with Busy/Ready Status

This block runs the timed programming cycle of a serial word-organised non-volatile memory. The command front end reports a fully received programming frame: a single word, a page, or a fill of the whole array. The sequencer then arms. It starts the cycle only when chip select falls before any further serial clock rise. It then waits a parameterised number of system clocks, which stands in for the cell programming time. After the wait it writes the array. A single word takes one clock, a page takes one clock per slot, and a fill takes one clock per location.

While the cycle runs, the block asserts `busy`, which tells the front end to reject new commands. Whenever chip select is high, the serial output reports status: 0 while programming and 1 once finished. The ready level persists, across chip-select low periods, until the start bit of the next command. When chip select is low, the output is released. The block also checks that chip select has stayed low for a minimum number of clocks between commands. A small read port exposes the array to the read path.

Top module: `eeprom_prog_seq`

## Requirements
- R1: When `frame_done` has armed the block and `cs` then falls with no `sk_rise` in between, `busy` is high from the next clock.
- R2: An `sk_rise` while armed and before `cs` falls cancels the cycle: `busy` stays low and the array is unchanged.
- R3: `busy` stays high for exactly PROG_CYCLES plus the update length. The update length is 1 for a word write (`frame_kind`=0), PAGE for a page write (`frame_kind`=1) and WORDS for a fill (`frame_kind`=2).
- R4: While `busy` is high and `cs` is high, `do_oe`=1 and `do_val`=0.
- R5: After a completed cycle, `do_oe`=1 and `do_val`=1 whenever `cs` is high. This holds across `cs` low periods until a `start_bit` is accepted.
- R6: While `cs` is low, `do_oe`=0.
- R7: With `cs` high, `do_oe`=0 in three cases: after reset, after an accepted `start_bit`, and while armed. It stays 0 until a cycle starts.
- R8: A word write replaces the word at `frame_addr` with `frame_data`, bit for bit, with no merge with the old value.
- R9: A page write visits slots `pg_idx`=0..PAGE-1 of the page aligned at `frame_addr`, whose low log2(PAGE) bits are cleared. Slot i is written with `pg_data` only where `pg_mask[i]`=1, and other slots keep their value.
- R10: A fill writes the `frame_data` word into every location within one cycle.
- R11: A `start_bit` or `frame_done` that arrives while `busy` is high is ignored: timing, array contents and the later ready report are unaffected.
- R12: `cs_gap_err` is high for one clock, one clock after `cs` rises, when `cs` was sampled low on fewer than CS_LOW_MIN clocks before the rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, synchronised to clk |
| sk_rise | input | 1 | One-clock strobe per serial clock rising edge |
| start_bit | input | 1 | One-clock strobe: start bit of a new command detected |
| frame_done | input | 1 | One-clock strobe: last data bit of a programming frame received |
| frame_kind | input | 2 | 0 word, 1 page, 2 fill |
| frame_addr | input | AW | Word address of the frame |
| frame_data | input | DW | Data word for word write or fill |
| pg_mask | input | PAGE | Page slots that hold received data |
| pg_idx | output | PW | Page slot being written |
| pg_data | input | DW | Page buffer word at `pg_idx` |
| rd_addr | input | AW | Array read address |
| rd_data | output | DW | Array read data |
| busy | output | 1 | Programming cycle in progress |
| do_val | output | 1 | Serial output level |
| do_oe | output | 1 | Serial output enable (0 = high impedance) |
| cs_gap_err | output | 1 | Chip-select low time too short |

## Verification
The assertions assume the following of the inputs:
- All control inputs are synchronous to `clk`.
- `frame_done` never arrives without a preceding `start_bit`.
- `pg_mask` and the buffer behind `pg_data` hold still for the whole cycle.

The stimulus keeps to these rules. Every frame it sends follows a start bit. It loads the page buffer and mask before arming and leaves them alone until `busy` falls. It also drives every input on the falling clock edge.

// File: rtl/eeprom_prog_pkg.sv
package eeprom_prog_pkg;
    typedef enum logic [1:0] {
        PK_WORD = 2'd0,
        PK_PAGE = 2'd1,
        PK_ALL  = 2'd2,
        PK_RSVD = 2'd3
    } prog_kind_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ARMED = 2'd1,
        SQ_COUNT = 2'd2,
        SQ_SWEEP = 2'd3
    } seq_state_e;
endpackage

// File: rtl/prog_timer.sv
module prog_timer #(
    parameter int LIMIT = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_d, cnt_q;
    logic          run_d, run_q;

    always_comb begin
        cnt_d   = cnt_q;
        run_d   = run_q;
        expired = run_q && (cnt_q == TW'(LIMIT - 1));
        if (start) begin
            cnt_d = '0;
            run_d = 1'b1;
        end else if (expired) begin
            run_d = 1'b0;
        end else if (run_q) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
        end
    end

    // R3: the running count never passes the programmed interval
    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q < TW'(LIMIT)));
endmodule

// File: rtl/cs_gap_check.sv
module cs_gap_check #(
    parameter int MIN_LOW = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    output logic err
);
    localparam int GW = $clog2(MIN_LOW + 1);

    logic [GW-1:0] low_d, low_q;
    logic          cs_q;
    logic          err_d, err_q;

    always_comb begin
        if (cs)
            low_d = '0;
        else if (low_q == GW'(MIN_LOW))
            low_d = low_q;
        else
            low_d = low_q + 1'b1;
        err_d = cs && !cs_q && (low_q < GW'(MIN_LOW));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= GW'(MIN_LOW);
            cs_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            low_q <= low_d;
            cs_q  <= cs;
            err_q <= err_d;
        end
    end

    assign err = err_q;

    // R12: an error pulse only follows a rising chip select
    p_err_after_rise_r12: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> cs_q);
endmodule

// File: rtl/prog_array.sv
module prog_array #(
    parameter int DW    = 16,
    parameter int WORDS = 64
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(WORDS)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(WORDS)-1:0] raddr,
    output logic [DW-1:0]            rdata
);
    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/eeprom_prog_seq.sv
module eeprom_prog_seq
    import eeprom_prog_pkg::*;
#(
    parameter int DW          = 16,
    parameter int WORDS       = 64,
    parameter int PAGE        = 4,
    parameter int PROG_CYCLES = 250000,
    parameter int CS_LOW_MIN  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs,
    input  logic                     sk_rise,
    input  logic                     start_bit,
    input  logic                     frame_done,
    input  logic [1:0]               frame_kind,
    input  logic [$clog2(WORDS)-1:0] frame_addr,
    input  logic [DW-1:0]            frame_data,
    input  logic [PAGE-1:0]          pg_mask,
    output logic [$clog2(PAGE)-1:0]  pg_idx,
    input  logic [DW-1:0]            pg_data,
    input  logic [$clog2(WORDS)-1:0] rd_addr,
    output logic [DW-1:0]            rd_data,
    output logic                     busy,
    output logic                     do_val,
    output logic                     do_oe,
    output logic                     cs_gap_err
);
    localparam int AW = $clog2(WORDS);
    localparam int PW = $clog2(PAGE);

    typedef struct packed {
        seq_state_e    st;
        prog_kind_e    kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [AW-1:0] sweep;
        logic          ready;
        logic          cs;
    } regs_t;

    regs_t         r_d, r_q;
    logic          tmr_start, tmr_expired;
    logic          cs_fall;
    logic          wr_en, sweep_last;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [PW-1:0] slot;

    assign slot = r_q.sweep[PW-1:0];

    always_comb begin
        r_d        = r_q;
        r_d.cs     = cs;
        cs_fall    = r_q.cs && !cs;
        tmr_start  = 1'b0;
        wr_en      = 1'b0;
        wr_addr    = r_q.addr;
        wr_data    = r_q.data;
        sweep_last = 1'b1;

        unique case (r_q.kind)
            PK_PAGE: begin
                wr_addr    = {r_q.addr[AW-1:PW], slot};
                wr_data    = pg_data;
                sweep_last = &slot;
            end
            PK_ALL: begin
                wr_addr    = r_q.sweep;
                sweep_last = &r_q.sweep;
            end
            default: ;
        endcase

        unique case (r_q.st)
            SQ_IDLE: begin
                if (start_bit)
                    r_d.ready = 1'b0;
                if (frame_done) begin
                    r_d.st    = SQ_ARMED;
                    r_d.kind  = prog_kind_e'(frame_kind);
                    r_d.addr  = frame_addr;
                    r_d.data  = frame_data;
                    r_d.ready = 1'b0;
                end
            end
            SQ_ARMED: begin
                if (sk_rise) begin
                    r_d.st = SQ_IDLE;
                end else if (cs_fall) begin
                    r_d.st    = SQ_COUNT;
                    tmr_start = 1'b1;
                end
            end
            SQ_COUNT: begin
                if (tmr_expired) begin
                    r_d.st    = SQ_SWEEP;
                    r_d.sweep = '0;
                end
            end
            SQ_SWEEP: begin
                wr_en = (r_q.kind == PK_PAGE) ? pg_mask[slot] : 1'b1;
                if (sweep_last) begin
                    r_d.st    = SQ_IDLE;
                    r_d.ready = 1'b1;
                end else begin
                    r_d.sweep = r_q.sweep + 1'b1;
                end
            end
            default: r_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= SQ_IDLE;
            r_q.kind  <= PK_WORD;
            r_q.addr  <= '0;
            r_q.data  <= '0;
            r_q.sweep <= '0;
            r_q.ready <= 1'b0;
            r_q.cs    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    prog_timer #(.LIMIT(PROG_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .expired (tmr_expired)
    );

    cs_gap_check #(.MIN_LOW(CS_LOW_MIN)) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .cs    (cs),
        .err   (cs_gap_err)
    );

    prog_array #(.DW(DW), .WORDS(WORDS)) u_array (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    assign pg_idx = slot;
    assign busy   = (r_q.st == SQ_COUNT) || (r_q.st == SQ_SWEEP);
    assign do_oe  = cs && (busy || r_q.ready);
    assign do_val = !busy;

    // R1: a chip-select fall while armed launches the cycle
    p_arm_fire_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SQ_ARMED && cs_fall && !sk_rise) |=> busy);

    // R2: a serial clock rise while armed drops the cycle
    p_cancel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SQ_ARMED && sk_rise) |=> (r_q.st == SQ_IDLE));

    // R5: the ready report survives until a start bit or new frame
    p_ready_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ready && !start_bit && !frame_done) |=> r_q.ready);

    // R6: output released while chip select is low
    p_hiz_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !do_oe);

    // R11: nothing but the timer ends the counting phase
    p_hold_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == SQ_COUNT && !tmr_expired) |=> (r_q.st == SQ_COUNT));

    // R9: array writes happen only inside a busy cycle
    p_write_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);
endmodule

// File: tb/sim_eeprom_prog_seq.sv
module sim_eeprom_prog_seq;
    localparam int DW = 16, WORDS = 16, PAGE = 4, PROG = 20, GAP = 4;
    localparam int AW = $clog2(WORDS), PW = $clog2(PAGE);

    typedef struct packed {
        logic [1:0]  kind;
        logic [3:0]  addr;
        logic [15:0] data;
        logic [3:0]  mask;
        logic [7:0]  busy_len;
        logic        poke;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{kind: 2'd2, addr: 4'd0,  data: 16'hA5A5, mask: 4'h0, busy_len: 8'd36, poke: 1'b0},
        '{kind: 2'd0, addr: 4'd5,  data: 16'h1234, mask: 4'h0, busy_len: 8'd21, poke: 1'b1},
        '{kind: 2'd1, addr: 4'd9,  data: 16'h0F0F, mask: 4'hB, busy_len: 8'd24, poke: 1'b0},
        '{kind: 2'd0, addr: 4'd15, data: 16'hFFFF, mask: 4'h0, busy_len: 8'd21, poke: 1'b0},
        '{kind: 2'd2, addr: 4'd7,  data: 16'h0000, mask: 4'h0, busy_len: 8'd36, poke: 1'b0},
        '{kind: 2'd0, addr: 4'd3,  data: 16'h8001, mask: 4'h0, busy_len: 8'd21, poke: 1'b0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs = 1'b0, sk_rise = 1'b0, start_bit = 1'b0, frame_done = 1'b0;
    logic [1:0] frame_kind = '0;
    logic [AW-1:0] frame_addr = '0, rd_addr = '0;
    logic [DW-1:0] frame_data = '0, pg_data, rd_data;
    logic [PAGE-1:0] pg_mask = '0;
    logic [PW-1:0] pg_idx;
    logic busy, do_val, do_oe, cs_gap_err;

    logic [DW-1:0] model [WORDS];
    logic [DW-1:0] pgbuf [PAGE];
    int n_chk = 0, n_fail = 0;
    bit prev_ready = 0;
    bit done = 0;

    always #10 clk = ~clk;
    assign pg_data = pgbuf[pg_idx];

    eeprom_prog_seq #(.DW(DW), .WORDS(WORDS), .PAGE(PAGE),
                      .PROG_CYCLES(PROG), .CS_LOW_MIN(GAP)) u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sk_rise(sk_rise),
        .start_bit(start_bit), .frame_done(frame_done), .frame_kind(frame_kind),
        .frame_addr(frame_addr), .frame_data(frame_data), .pg_mask(pg_mask),
        .pg_idx(pg_idx), .pg_data(pg_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .do_val(do_val), .do_oe(do_oe), .cs_gap_err(cs_gap_err)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic check_mem(input string req);
        for (int a = 0; a < WORDS; a++) begin
            rd_addr = AW'(a);
            #1;
            chk(req, rd_data, model[a]);
        end
    endtask

    task automatic run_prog(input vec_t v);
        int cnt;
        int base;
        cs = 1'b1;
        tick();
        chk("R5/R7 oe before start bit", do_oe, prev_ready);
        if (prev_ready) chk("R5 ready level kept", do_val, 1'b1);
        start_bit = 1'b1;
        tick();
        start_bit = 1'b0;
        tick();
        chk("R7 oe after start bit", do_oe, 1'b0);
        for (int i = 0; i < PAGE; i++) pgbuf[i] = v.data ^ (16'h1111 * DW'(i));
        pg_mask    = v.mask;
        frame_kind = v.kind;
        frame_addr = v.addr;
        frame_data = v.data;
        frame_done = 1'b1;
        tick();
        frame_done = 1'b0;
        tick();
        chk("R7 oe while armed", do_oe, 1'b0);
        cs = 1'b0;
        tick();
        chk("R1 busy after cs fall", busy, 1'b1);
        cnt = 0;
        while (busy && cnt < 1000) begin
            cnt++;
            if (cnt == 5) cs = 1'b1;
            if (cnt == 6) begin
                chk("R4 oe while busy", do_oe, 1'b1);
                chk("R4 level while busy", do_val, 1'b0);
                chk("R12 no error on long low", cs_gap_err, 1'b0);
            end
            if (v.poke && cnt == 8) begin
                start_bit  = 1'b1;
                frame_done = 1'b1;
                frame_kind = 2'd0;
                frame_addr = '0;
                frame_data = 16'hBEEF;
            end
            if (v.poke && cnt == 9) begin
                start_bit  = 1'b0;
                frame_done = 1'b0;
            end
            tick();
        end
        chk(v.poke ? "R11 busy length with ignored command" : "R3 busy length",
            cnt, 32'(v.busy_len));
        chk("R5 ready after cycle", {do_oe, do_val}, 2'b11);
        cs = 1'b0;
        repeat (5) tick();
        chk("R6 released with cs low", do_oe, 1'b0);
        case (v.kind)
            2'd2: for (int a = 0; a < WORDS; a++) model[a] = v.data;
            2'd1: begin
                base = int'(v.addr) & ~(PAGE - 1);
                for (int i = 0; i < PAGE; i++)
                    if (v.mask[i]) model[base + i] = pgbuf[i];
            end
            default: model[v.addr] = v.data;
        endcase
        check_mem(v.kind == 2'd2 ? "R10 fill contents" :
                  v.kind == 2'd1 ? "R9 page contents" : "R8 word replaced");
        prev_ready = 1;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        bit saw_busy;
        for (int i = 0; i < PAGE; i++) pgbuf[i] = '0;
        cs = 1'b1;
        repeat (3) tick();
        chk("R7 reset oe", do_oe, 1'b0);
        chk("R3 reset busy", busy, 1'b0);
        chk("R12 reset error", cs_gap_err, 1'b0);
        rst_n = 1'b1;
        tick();
        tick();
        chk("R7 no report without cycle", do_oe, 1'b0);
        cs = 1'b0;
        repeat (6) tick();

        for (int k = 0; k < 6; k++) run_prog(VECS[k]);

        // R2: cancelled arming
        cs = 1'b1;
        tick();
        start_bit = 1'b1;
        tick();
        start_bit = 1'b0;
        frame_kind = 2'd0;
        frame_addr = 4'd2;
        frame_data = 16'hDEAD;
        frame_done = 1'b1;
        tick();
        frame_done = 1'b0;
        sk_rise = 1'b1;
        tick();
        sk_rise = 1'b0;
        cs = 1'b0;
        saw_busy = 0;
        repeat (8) begin
            tick();
            if (busy) saw_busy = 1;
        end
        chk("R2 no cycle after sk rise", saw_busy, 1'b0);
        cs = 1'b1;
        tick();
        chk("R7 no report after cancel", do_oe, 1'b0);
        rd_addr = 4'd2;
        #1;
        chk("R2 array untouched", rd_data, model[2]);

        // R12: gap check
        cs = 1'b0;
        repeat (3) tick();
        cs = 1'b1;
        tick();
        chk("R12 short low flagged", cs_gap_err, 1'b1);
        tick();
        chk("R12 error is one clock", cs_gap_err, 1'b0);
        cs = 1'b0;
        repeat (4) tick();
        cs = 1'b1;
        tick();
        chk("R12 minimum low accepted", cs_gap_err, 1'b0);

        done = 1;
        summary();
    end
endmodule